// File: doc/BRIEF.md
# Boxed Single-Precision Sign, Classify and Move Unit

This unit carries out the non-arithmetic single-precision operations for a core whose floating-point registers are 64 bits wide. A 32-bit value sits in such a register in the lower half, with the upper half filled with ones. The unit takes two raw 64-bit register values and an operation code. It performs one of three things: a sign-injection variant, a classification of the first operand, or a move of the first operand to an integer register with sign extension. The results are registered, and a one-cycle `done` pulse follows every accepted `valid`.

Before any operand is used by sign injection or classification, the unit checks its upper half. If the upper half is not all ones, the operand is replaced by the single-precision canonical quiet NaN. The move-to-integer operation skips this check and copies the low 32 bits unchanged. Every floating-point result is written back with its upper half forced to ones.

A two-state controller sequences the unit. In `S_IDLE`, `done` is low. A cycle with `valid` high takes the `GO` transition into `S_DONE`, and the results are captured on the same edge. `S_DONE` raises `done` for one cycle. From there, another `valid` takes `AGAIN` and stays in `S_DONE`, while an idle cycle takes `REST` back to `S_IDLE`. A cycle in `S_IDLE` without `valid` takes `WAIT` and stays put.

Top module: `sp_misc_unit`

## Requirements
- R1: After a synchronous active-high reset, `done` is 0 and both `fp_res` and `int_res` read zero.
- R2: `done` is high in exactly the cycle after each cycle with `valid` high, and in no other cycle. Outputs hold their value between operations.
- R3: An operand counts as boxed only when bits 63:32 are all ones. For op codes 0 to 3, an unboxed operand is replaced by 0x7fc00000, and this includes the case where only one of the upper bits is zero.
- R4: Op code 0 (plain injection) gives `fp_res` = {32 ones, sign of operand B, bits 30:0 of operand A}, and `int_res` = 0.
- R5: Op code 1 (negated injection) works like R4 but uses the inverse of operand B's sign.
- R6: Op code 2 (XOR injection) uses as sign bit 31 of A XOR bit 31 of B, both taken after substitution. An unboxed A therefore gives 0xffffffff7fc00000 when B is positive.
- R7: Op code 3 (classify) gives `fp_res` = 0 and puts a one-hot code in `int_res[9:0]`, zero-extended. The bits are: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN.
- R8: Classify of an unboxed operand gives exactly 0x200.
- R9: Op code 4 (move to integer) gives `int_res` = bits 31:0 of A with bit 31 sign-extended to 64 bits, regardless of boxing, and `fp_res` = 0.
- R10: Op codes 5, 6 and 7 give zero on both results while `done` still pulses.
- R11: Every result of op codes 0 to 2 has bits 63:32 all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Starts an operation this cycle |
| op_sel | input | 3 | Operation code (see R4 to R10) |
| a_in | input | 64 | Raw register value, operand A |
| b_in | input | 64 | Raw register value, operand B |
| fp_res | output | 64 | Floating-point result, boxed |
| int_res | output | 64 | Integer result |
| done | output | 1 | Result-ready pulse |

## Verification
The assertions assume that `valid`, `op_sel` and both operands are known (not X) on every clock edge outside reset, and that `valid` is low during reset. The bench drives all inputs at falling edges with fully specified values. It keeps `valid` low until reset has been released. `op_sel` stays within its three bits, so the reserved codes are reached only on purpose.

// File: rtl/sp_misc_pkg.sv
package sp_misc_pkg;

    typedef enum logic [2:0] {
        OP_SGNJ   = 3'd0,
        OP_SGNJN  = 3'd1,
        OP_SGNJX  = 3'd2,
        OP_CLASS  = 3'd3,
        OP_MVX    = 3'd4,
        OP_RSVD5  = 3'd5,
        OP_RSVD6  = 3'd6,
        OP_RSVD7  = 3'd7
    } op_e;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } state_e;

    localparam int CLS_W     = 10;
    localparam int CLS_NINF  = 0;
    localparam int CLS_NNORM = 1;
    localparam int CLS_NSUB  = 2;
    localparam int CLS_NZERO = 3;
    localparam int CLS_PZERO = 4;
    localparam int CLS_PSUB  = 5;
    localparam int CLS_PNORM = 6;
    localparam int CLS_PINF  = 7;
    localparam int CLS_SNAN  = 8;
    localparam int CLS_QNAN  = 9;

endpackage

// File: rtl/sp_unbox.sv
module sp_unbox #(
    parameter int XLEN = 64,
    parameter int SW   = 32,
    parameter int EXPW = 8
) (
    input  logic [XLEN-1:0] raw,
    output logic [SW-1:0]   val
);
    localparam int FRACW = SW - 1 - EXPW;
    localparam logic [SW-1:0] CANON_QNAN =
        {1'b0, {EXPW{1'b1}}, 1'b1, {(FRACW-1){1'b0}}};

    logic is_boxed;

    always_comb begin
        is_boxed = &raw[XLEN-1:SW];
        val      = is_boxed ? raw[SW-1:0] : CANON_QNAN;
    end
endmodule

// File: rtl/sp_sgninj.sv
module sp_sgninj #(
    parameter int SW = 32
) (
    input  logic [SW-1:0] opa,
    input  logic [SW-1:0] opb,
    input  logic [1:0]    mode,
    output logic [SW-1:0] res
);
    logic new_sign;

    always_comb begin
        unique case (mode)
            2'd0:    new_sign = opb[SW-1];
            2'd1:    new_sign = ~opb[SW-1];
            2'd2:    new_sign = opa[SW-1] ^ opb[SW-1];
            default: new_sign = opa[SW-1];
        endcase
        res = {new_sign, opa[SW-2:0]};
    end
endmodule

// File: rtl/sp_classify.sv
module sp_classify
    import sp_misc_pkg::*;
#(
    parameter int SW   = 32,
    parameter int EXPW = 8
) (
    input  logic [SW-1:0]    val,
    output logic [CLS_W-1:0] cls
);
    localparam int FRACW = SW - 1 - EXPW;

    logic             sgn;
    logic [EXPW-1:0]  expo;
    logic [FRACW-1:0] frac;
    logic             exp_ones, exp_zero, frac_zero;

    always_comb begin
        sgn       = val[SW-1];
        expo      = val[SW-2:FRACW];
        frac      = val[FRACW-1:0];
        exp_ones  = &expo;
        exp_zero  = ~|expo;
        frac_zero = ~|frac;
        cls       = '0;
        if (exp_ones && !frac_zero) begin
            if (frac[FRACW-1]) cls[CLS_QNAN] = 1'b1;
            else               cls[CLS_SNAN] = 1'b1;
        end else if (exp_ones) begin
            if (sgn) cls[CLS_NINF] = 1'b1;
            else     cls[CLS_PINF] = 1'b1;
        end else if (exp_zero && frac_zero) begin
            if (sgn) cls[CLS_NZERO] = 1'b1;
            else     cls[CLS_PZERO] = 1'b1;
        end else if (exp_zero) begin
            if (sgn) cls[CLS_NSUB] = 1'b1;
            else     cls[CLS_PSUB] = 1'b1;
        end else begin
            if (sgn) cls[CLS_NNORM] = 1'b1;
            else     cls[CLS_PNORM] = 1'b1;
        end
    end
endmodule

// File: rtl/sp_misc_unit.sv
module sp_misc_unit
    import sp_misc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SW   = 32,
    parameter int EXPW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic [2:0]      op_sel,
    input  logic [XLEN-1:0] a_in,
    input  logic [XLEN-1:0] b_in,
    output logic [XLEN-1:0] fp_res,
    output logic [XLEN-1:0] int_res,
    output logic            done
);
    localparam int NOPND = 2;
    localparam int UPW   = XLEN - SW;
    localparam int FRACW = SW - 1 - EXPW;
    localparam logic [SW-2:0] QNAN_LOW = {{EXPW{1'b1}}, 1'b1, {(FRACW-1){1'b0}}};

    logic [XLEN-1:0]  raw_arr [NOPND];
    logic [SW-1:0]    opnd    [NOPND];
    logic [SW-1:0]    inj_res;
    logic [CLS_W-1:0] cls_code;
    logic [XLEN-1:0]  fp_nxt, int_nxt;
    state_e           state_q, state_d;
    op_e              op;

    assign raw_arr[0] = a_in;
    assign raw_arr[1] = b_in;
    assign op         = op_e'(op_sel);

    for (genvar g = 0; g < NOPND; g++) begin : g_unbox
        sp_unbox #(.XLEN(XLEN), .SW(SW), .EXPW(EXPW)) unbox_i (
            .raw (raw_arr[g]),
            .val (opnd[g])
        );
    end

    sp_sgninj #(.SW(SW)) sgninj_i (
        .opa  (opnd[0]),
        .opb  (opnd[1]),
        .mode (op_sel[1:0]),
        .res  (inj_res)
    );

    sp_classify #(.SW(SW), .EXPW(EXPW)) classify_i (
        .val (opnd[0]),
        .cls (cls_code)
    );

    // Result selection
    always_comb begin
        fp_nxt  = '0;
        int_nxt = '0;
        unique case (op)
            OP_SGNJ, OP_SGNJN, OP_SGNJX: fp_nxt = {{UPW{1'b1}}, inj_res};
            OP_CLASS: int_nxt = {{(XLEN-CLS_W){1'b0}}, cls_code};
            OP_MVX:   int_nxt = {{UPW{a_in[SW-1]}}, a_in[SW-1:0]};
            default: begin
                fp_nxt  = '0;
                int_nxt = '0;
            end
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = valid ? S_DONE : S_IDLE;  // GO / WAIT
            S_DONE:  state_d = valid ? S_DONE : S_IDLE;  // AGAIN / REST
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            fp_res  <= '0;
            int_res <= '0;
        end else if (valid) begin
            fp_res  <= fp_nxt;
            int_res <= int_nxt;
        end
    end

    assign done = (state_q == S_DONE);

    AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (rst)
        valid |=> done);  // R2
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(valid));  // R2
    AST_UNBOXED_SUBST: assert property (@(posedge clk) disable iff (rst)
        (valid && op_sel <= 3'd2 && !(&a_in[XLEN-1:SW]))
        |=> fp_res[SW-2:0] == QNAN_LOW);  // R3
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (valid && op_sel == 3'd3)
        |=> ($countones(int_res[CLS_W-1:0]) == 1 && int_res[XLEN-1:CLS_W] == '0));  // R7
    AST_MVX_SIGNEXT: assert property (@(posedge clk) disable iff (rst)
        (valid && op_sel == 3'd4)
        |=> int_res[XLEN-1:SW] == {UPW{$past(a_in[SW-1])}});  // R9
    AST_FP_BOXED: assert property (@(posedge clk) disable iff (rst)
        (valid && op_sel <= 3'd2) |=> &fp_res[XLEN-1:SW]);  // R11
endmodule

// File: tb/sp_misc_unit_tb.sv
`timescale 1ns/1ps
module sp_misc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [63:0] a_in = '0, b_in = '0;
    logic [63:0] fp_res, int_res;
    logic        done;

    int checks = 0;
    int fails  = 0;

    logic [63:0] q_fp[$];
    logic [63:0] q_int[$];
    string       q_tag[$];
    logic [63:0] last_fp = '0, last_int = '0;

    always #2.5 clk = ~clk;

    sp_misc_unit dut_i (
        .clk, .rst, .valid, .op_sel, .a_in, .b_in,
        .fp_res, .int_res, .done
    );

    // Reference model
    function automatic logic [31:0] m_unbox(input logic [63:0] x);
        return (x[63:32] == 32'hffffffff) ? x[31:0] : 32'h7fc00000;
    endfunction

    function automatic logic [63:0] m_class(input logic [31:0] v);
        logic [9:0] c = '0;
        if (v[30:23] == 8'hff && v[22:0] != 0) c[v[22] ? 9 : 8] = 1'b1;
        else if (v[30:23] == 8'hff)            c[v[31] ? 0 : 7] = 1'b1;
        else if (v[30:0] == 0)                 c[v[31] ? 3 : 4] = 1'b1;
        else if (v[30:23] == 8'h00)            c[v[31] ? 2 : 5] = 1'b1;
        else                                   c[v[31] ? 1 : 6] = 1'b1;
        return {54'd0, c};
    endfunction

    task automatic model(input logic [2:0] op, input logic [63:0] a, b,
                         output logic [63:0] efp, output logic [63:0] eint);
        logic [31:0] ua = m_unbox(a);
        logic [31:0] ub = m_unbox(b);
        efp = '0; eint = '0;
        case (op)
            3'd0: efp  = {32'hffffffff, ub[31], ua[30:0]};
            3'd1: efp  = {32'hffffffff, ~ub[31], ua[30:0]};
            3'd2: efp  = {32'hffffffff, ua[31] ^ ub[31], ua[30:0]};
            3'd3: eint = m_class(ua);
            3'd4: eint = {{32{a[31]}}, a[31:0]};
            default: ;
        endcase
    endtask

    // Driver
    task automatic send(input logic [2:0] op, input logic [63:0] a, b, input string tag);
        logic [63:0] efp, eint;
        @(negedge clk);
        op_sel = op; a_in = a; b_in = b; valid = 1'b1;
        model(op, a, b, efp, eint);
        q_fp.push_back(efp); q_int.push_back(eint); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid = 1'b0;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q_fp.size() == 0) begin
                chk(1'b0, "R2 spurious done", 64'd1, 64'd0);
            end else begin
                logic [63:0] efp, eint;
                string t;
                efp = q_fp.pop_front(); eint = q_int.pop_front(); t = q_tag.pop_front();
                chk(fp_res == efp, {t, " fp"}, fp_res, efp);
                chk(int_res == eint, {t, " int"}, int_res, eint);
                last_fp = efp; last_int = eint;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1 done", {63'd0, done}, 64'd0);
        chk(fp_res == 0 && int_res == 0, "R1 results", fp_res | int_res, 64'd0);

        // Sign injection
        send(3'd2, 64'hcfa695b1047553b1, 64'hffffffff00000000, "R6 R3 xor unboxed A");
        send(3'd2, 64'hffffffff7b3754ef, 64'hffffffff80000000, "R6 R11 xor boxed");
        send(3'd0, 64'hffffffff3f800000, 64'hffffffffc0000000, "R4 plain neg");
        send(3'd0, 64'hffffffffbf800000, 64'hffffffff40000000, "R4 plain pos");
        send(3'd1, 64'hffffffff3f800000, 64'hffffffff40000000, "R5 negated");
        send(3'd1, 64'hffffffff3f800000, 64'h0000000080000000, "R5 R3 negated unboxed B");
        send(3'd0, 64'hfffffffe3f800000, 64'hffffffff80000000, "R3 one upper bit clear");
        idle(1);

        // Classify
        send(3'd3, 64'hffffffffff800000, 0, "R7 neg inf");
        send(3'd3, 64'hffffffffbf800000, 0, "R7 neg normal");
        send(3'd3, 64'hffffffff80000001, 0, "R7 neg subnormal");
        send(3'd3, 64'hffffffff80000000, 0, "R7 neg zero");
        send(3'd3, 64'hffffffff00000000, 0, "R7 pos zero");
        send(3'd3, 64'hffffffff00000001, 0, "R7 pos subnormal");
        send(3'd3, 64'hffffffff3f800000, 0, "R7 pos normal");
        send(3'd3, 64'hffffffff7f800000, 0, "R7 pos inf");
        send(3'd3, 64'hffffffff7f800001, 0, "R7 signaling nan");
        send(3'd3, 64'hffffffff7fc00000, 0, "R7 quiet nan");
        send(3'd3, 64'h0000000000000000, 0, "R8 unboxed classify");
        idle(1);

        // Move to integer
        send(3'd4, 64'h00000000ffffffff, 0, "R9 unboxed negative");
        send(3'd4, 64'hffffffff12345678, 0, "R9 boxed positive");

        // Reserved codes
        send(3'd5, 64'hffffffff3f800000, 64'hffffffff3f800000, "R10 code5");
        send(3'd6, 64'hffffffff3f800000, 64'hffffffff3f800000, "R10 code6");
        send(3'd7, 64'hffffffff3f800000, 64'h1, "R10 code7");

        // Hold and no spurious done
        send(3'd4, 64'h0000000080000001, 0, "R9 R2 before hold");
        idle(4);
        chk(done == 1'b0, "R2 done idle", {63'd0, done}, 64'd0);
        chk(fp_res == last_fp && int_res == last_int, "R2 hold", int_res, last_int);

        idle(3);
        chk(q_fp.size() == 0, "R2 all results seen", 64'(q_fp.size()), 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule